// File: doc/BRIEF.md
# Three-Port Latched Bus Exchanger

The block connects one 12-bit A bus to two 12-bit B buses, bank 1 and bank 2. Data can flow in both directions. Each direction of each bank has its own storage latch, so the block holds four latches in total. On the way from B to A, a select input chooses which bank's latch drives A. On the way from A to B, each bank latches A separately. Each of the three ports has an active-low output enable. The two B-side enables also decide which banks receive A data: bank 1 only, bank 2 only, both, or neither. Typical uses are splitting a shared address/data bus and interleaving two memory banks.

Each latch is built as a clocked register with a bypass. While its enable is high, the output follows the input in the same cycle, and the register is loaded on every rising clock edge. While the enable is low, the output shows the register. The value that is kept is the one present at the last rising edge during which the enable was high. A synchronous active-low reset clears all four latches and the keepers.

Each bidirectional port is split into plain signals: an input, a flag that says an outside driver is active, an output, and an output enable. A keeper per port remembers the last level seen on the pad. When neither side drives the port, the latches see that remembered level. The keeper register takes the block's own output whenever the block drives the port. As a result the combinational paths only ever start from outside inputs or registers, and no loop can form through two transparent latches.

Top module: `bx_exchange`

## Requirements
- R1: While `rst_n` is low at a rising edge, all four latches and all three keepers load zero. After reset, with every latch enable low, `a_out`, `b1_out` and `b2_out` read 0.
- R2: When `sel`=1 and `le_b1a`=1, `a_out` equals the level that bank 1 presents, in the same cycle. That level is `b1_in` if `b1_drv`=1, otherwise the bank-1 keeper value.
- R3: When `sel`=0 and `le_b2a`=1, `a_out` equals the level that bank 2 presents, in the same cycle.
- R4: When a latch enable is low, that latch's output equals its input as sampled at the last rising edge at which the enable was high. Later changes at its input have no effect.
- R5: `a_oe` is 1 exactly when `oe_a_n` is 0. When `oe_a_n` is 1, A is released whatever the other inputs are.
- R6: `b1_out` follows the level A presents while `le_ab1`=1, and `b2_out` does the same under `le_ab2`. The level A presents is `a_in` if `a_drv`=1, otherwise the A keeper value.
- R7: `b1_oe` is 1 exactly when `oe_b1_n` is 0, and `b2_oe` is 1 exactly when `oe_b2_n` is 0. The two are independent, so A data can be steered to one bank, both banks or neither.
- R8: Each latch loads only under its own enable. Toggling `sel` or any output enable never changes what is stored.
- R9: At each rising edge, a port's keeper loads the block's own output if that port's enable is active. Otherwise it loads the outside input if the outside driver is active. Otherwise it holds. A port with no driver presents its keeper value to the latches.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous reset, active low |
| sel | input | 1 | B-to-A bank select: 1 = bank 1, 0 = bank 2 |
| le_b1a | input | 1 | Latch enable, bank 1 to A |
| le_b2a | input | 1 | Latch enable, bank 2 to A |
| le_ab1 | input | 1 | Latch enable, A to bank 1 |
| le_ab2 | input | 1 | Latch enable, A to bank 2 |
| oe_a_n | input | 1 | A output enable, active low |
| oe_b1_n | input | 1 | Bank 1 output enable, active low |
| oe_b2_n | input | 1 | Bank 2 output enable, active low |
| a_drv | input | 1 | Outside driver active on A |
| a_in | input | 12 | Outside level on A |
| a_out | output | 12 | Block's data for A |
| a_oe | output | 1 | Block drives A |
| b1_drv | input | 1 | Outside driver active on bank 1 |
| b1_in | input | 12 | Outside level on bank 1 |
| b1_out | output | 12 | Block's data for bank 1 |
| b1_oe | output | 1 | Block drives bank 1 |
| b2_drv | input | 1 | Outside driver active on bank 2 |
| b2_in | input | 12 | Outside level on bank 2 |
| b2_out | output | 12 | Block's data for bank 2 |
| b2_oe | output | 1 | Block drives bank 2 |

## Verification
The output enables and transparent data paths respond in the same cycle, with no register on the way. The bench therefore drives inputs at the falling edge and compares outputs one nanosecond later. Stored and kept values change only at a rising edge. The bench reference model updates its latch and keeper copies right after each rising edge, using the inputs of the cycle that just ended. Every output is then compared at the following falling edge. This ordering holds the hold cases (R4), the keeper cases (R9) and reset (R1) to exactly one edge of latency.

// File: rtl/bx_pkg.sv
package bx_pkg;
  localparam int BX_W = 12;
  localparam int BX_BANKS = 2;

  typedef enum logic {
    SEL_BANK2 = 1'b0,
    SEL_BANK1 = 1'b1
  } bank_sel_e;

  function automatic int bank_index(input bank_sel_e s);
    return (s == SEL_BANK1) ? 0 : 1;
  endfunction
endpackage

// File: rtl/bx_latch.sv
module bx_latch #(
  parameter int W = bx_pkg::BX_W
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         le,
  input  logic [W-1:0] d,
  output logic [W-1:0] q
);
  logic [W-1:0] store_q;

  always_ff @(posedge clk) begin
    if (!rst_n)  store_q <= '0;
    else if (le) store_q <= d;
  end

  // Transparent while enabled, stored value otherwise
  assign q = le ? d : store_q;

  AST_LATCH_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    !le |=> $stable(store_q)); // R4
  AST_LATCH_CAPTURE: assert property (@(posedge clk) disable iff (!rst_n)
    le |=> (store_q == $past(d))); // R4
endmodule

// File: rtl/bx_keeper.sv
module bx_keeper #(
  parameter int W = bx_pkg::BX_W,
  parameter bit KEEP_EN = 1'b1
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         ext_drv,
  input  logic [W-1:0] ext_in,
  input  logic         own_oe,
  input  logic [W-1:0] own_out,
  output logic [W-1:0] seen
);
  generate
    if (KEEP_EN) begin : g_keep
      logic [W-1:0] held_q;

      always_ff @(posedge clk) begin
        if (!rst_n)       held_q <= '0;
        else if (own_oe)  held_q <= own_out;
        else if (ext_drv) held_q <= ext_in;
      end

      assign seen = ext_drv ? ext_in : held_q;

      AST_KEEP_STABLE: assert property (@(posedge clk) disable iff (!rst_n)
        (!own_oe && !ext_drv) |=> $stable(held_q)); // R9
      AST_KEEP_FOLLOW: assert property (@(posedge clk) disable iff (!rst_n)
        (!own_oe && ext_drv) |=> (held_q == $past(ext_in))); // R9
    end else begin : g_nokeep
      logic unused_ok;
      assign unused_ok = ^{clk, rst_n, own_oe, own_out};
      assign seen = ext_drv ? ext_in : '0;
    end
  endgenerate
endmodule

// File: rtl/bx_exchange.sv
module bx_exchange #(
  parameter int W = bx_pkg::BX_W,
  parameter bit KEEP_EN = 1'b1
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         sel,
  input  logic         le_b1a,
  input  logic         le_b2a,
  input  logic         le_ab1,
  input  logic         le_ab2,
  input  logic         oe_a_n,
  input  logic         oe_b1_n,
  input  logic         oe_b2_n,
  input  logic         a_drv,
  input  logic [W-1:0] a_in,
  output logic [W-1:0] a_out,
  output logic         a_oe,
  input  logic         b1_drv,
  input  logic [W-1:0] b1_in,
  output logic [W-1:0] b1_out,
  output logic         b1_oe,
  input  logic         b2_drv,
  input  logic [W-1:0] b2_in,
  output logic [W-1:0] b2_out,
  output logic         b2_oe
);
  import bx_pkg::*;
  localparam int NB = BX_BANKS;

  logic [NB-1:0][W-1:0] b_in_v, b_seen, ba_q, ab_q;
  logic [NB-1:0]        b_drv_v, le_ba_v, le_ab_v, b_oe_v;
  logic [W-1:0]         a_seen;
  bank_sel_e            sel_e;

  assign b_in_v  = {b2_in, b1_in};
  assign b_drv_v = {b2_drv, b1_drv};
  assign le_ba_v = {le_b2a, le_b1a};
  assign le_ab_v = {le_ab2, le_ab1};
  assign b_oe_v  = {~oe_b2_n, ~oe_b1_n};

  // A side pad keeper; fed back from the block's own driven value
  bx_keeper #(.W(W), .KEEP_EN(KEEP_EN)) u_keep_a (
    .clk(clk), .rst_n(rst_n), .ext_drv(a_drv), .ext_in(a_in),
    .own_oe(a_oe), .own_out(a_out), .seen(a_seen)
  );

  generate
    for (genvar g = 0; g < NB; g++) begin : g_bank
      bx_keeper #(.W(W), .KEEP_EN(KEEP_EN)) u_keep_b (
        .clk(clk), .rst_n(rst_n), .ext_drv(b_drv_v[g]), .ext_in(b_in_v[g]),
        .own_oe(b_oe_v[g]), .own_out(ab_q[g]), .seen(b_seen[g])
      );
      bx_latch #(.W(W)) u_lat_ba (
        .clk(clk), .rst_n(rst_n), .le(le_ba_v[g]), .d(b_seen[g]), .q(ba_q[g])
      );
      bx_latch #(.W(W)) u_lat_ab (
        .clk(clk), .rst_n(rst_n), .le(le_ab_v[g]), .d(a_seen), .q(ab_q[g])
      );
    end
  endgenerate

  assign sel_e  = bank_sel_e'(sel);
  assign a_out  = ba_q[bank_index(sel_e)];
  assign a_oe   = ~oe_a_n;
  assign b1_out = ab_q[0];
  assign b2_out = ab_q[1];
  assign b1_oe  = b_oe_v[0];
  assign b2_oe  = b_oe_v[1];

  AST_SEL_BANK1: assert property (@(posedge clk) disable iff (!rst_n)
    (sel && le_b1a && b1_drv) |-> (a_out == b1_in)); // R2
  AST_SEL_BANK2: assert property (@(posedge clk) disable iff (!rst_n)
    (!sel && le_b2a && b2_drv) |-> (a_out == b2_in)); // R3
  AST_A_TO_B1: assert property (@(posedge clk) disable iff (!rst_n)
    (le_ab1 && a_drv) |-> (b1_out == a_in)); // R6
  AST_A_TO_B2: assert property (@(posedge clk) disable iff (!rst_n)
    (le_ab2 && a_drv) |-> (b2_out == a_in)); // R6
endmodule

// File: tb/bx_exchange_bench.sv
module bx_exchange_bench;
  localparam int W = 12;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic sel = 1'b0, le_b1a = 1'b0, le_b2a = 1'b0, le_ab1 = 1'b0, le_ab2 = 1'b0;
  logic oe_a_n = 1'b1, oe_b1_n = 1'b1, oe_b2_n = 1'b1;
  logic a_drv = 1'b0, b1_drv = 1'b0, b2_drv = 1'b0;
  logic [W-1:0] a_in = '0, b1_in = '0, b2_in = '0;
  logic [W-1:0] a_out, b1_out, b2_out;
  logic a_oe, b1_oe, b2_oe;

  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  // reference state
  logic [W-1:0] m_ba1 = '0, m_ba2 = '0, m_ab1 = '0, m_ab2 = '0;
  logic [W-1:0] k_a = '0, k_b1 = '0, k_b2 = '0;
  logic [W-1:0] e_a, e_b1, e_b2;

  always #5 clk = ~clk;

  bx_exchange #(.W(W), .KEEP_EN(1'b1)) u_bx_exchange (
    .clk(clk), .rst_n(rst_n), .sel(sel), .le_b1a(le_b1a), .le_b2a(le_b2a),
    .le_ab1(le_ab1), .le_ab2(le_ab2), .oe_a_n(oe_a_n), .oe_b1_n(oe_b1_n),
    .oe_b2_n(oe_b2_n), .a_drv(a_drv), .a_in(a_in), .a_out(a_out), .a_oe(a_oe),
    .b1_drv(b1_drv), .b1_in(b1_in), .b1_out(b1_out), .b1_oe(b1_oe),
    .b2_drv(b2_drv), .b2_in(b2_in), .b2_out(b2_out), .b2_oe(b2_oe)
  );

  function automatic logic [W-1:0] pad_level(input logic drv, input logic [W-1:0] din,
                                             input logic [W-1:0] held);
    return drv ? din : held;
  endfunction

  task automatic check(input string req, input string what, input logic [W-1:0] got,
                       input logic [W-1:0] exp);
    checks++;
    if (got !== exp) begin
      errors++;
      $display("FAIL %s %s actual=%h expected=%h", req, what, got, exp);
    end
  endtask

  // Inputs were set at the falling edge; check, then advance one cycle.
  task automatic step();
    logic [W-1:0] sa, s1, s2;
    string ta, t1, t2;
    #1;
    sa = pad_level(a_drv, a_in, k_a);
    s1 = pad_level(b1_drv, b1_in, k_b1);
    s2 = pad_level(b2_drv, b2_in, k_b2);
    e_b1 = le_ab1 ? sa : m_ab1;
    e_b2 = le_ab2 ? sa : m_ab2;
    e_a  = sel ? (le_b1a ? s1 : m_ba1) : (le_b2a ? s2 : m_ba2);
    ta = sel ? (le_b1a ? "R2" : "R4") : (le_b2a ? "R3" : "R4");
    t1 = le_ab1 ? "R6" : "R4";
    t2 = le_ab2 ? "R6" : "R4";
    if (rst_n) begin
      check(ta, "a_out", a_out, e_a);
      check(t1, "b1_out", b1_out, e_b1);
      check(t2, "b2_out", b2_out, e_b2);
    end
    check("R5", "a_oe", W'(a_oe), W'(!oe_a_n));
    check("R7", "b1_oe", W'(b1_oe), W'(!oe_b1_n));
    check("R7", "b2_oe", W'(b2_oe), W'(!oe_b2_n));
    @(posedge clk);
    if (!rst_n) begin
      m_ba1 = '0; m_ba2 = '0; m_ab1 = '0; m_ab2 = '0;
      k_a = '0; k_b1 = '0; k_b2 = '0;
    end else begin
      if (le_b1a) m_ba1 = s1;
      if (le_b2a) m_ba2 = s2;
      if (le_ab1) m_ab1 = sa;
      if (le_ab2) m_ab2 = sa;
      k_a  = !oe_a_n  ? e_a  : (a_drv  ? a_in  : k_a);
      k_b1 = !oe_b1_n ? e_b1 : (b1_drv ? b1_in : k_b1);
      k_b2 = !oe_b2_n ? e_b2 : (b2_drv ? b2_in : k_b2);
    end
    @(negedge clk);
  endtask

  task automatic quiet();
    le_b1a = 0; le_b2a = 0; le_ab1 = 0; le_ab2 = 0;
    oe_a_n = 1; oe_b1_n = 1; oe_b2_n = 1;
    a_drv = 0; b1_drv = 0; b2_drv = 0;
  endtask

  initial begin
    #2_000_000;
    if (!done) begin
      errors++;
      $display("FAIL watchdog expired");
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'd1311));
    @(negedge clk);
    // R1: reset with busy inputs
    a_drv = 1; a_in = 12'h5A5; b1_drv = 1; b1_in = 12'h3C3; le_ab1 = 1; le_b1a = 1;
    step(); step(); step();
    quiet(); rst_n = 1;
    #1;
    check("R1", "a_out after reset", a_out, '0);
    check("R1", "b1_out after reset", b1_out, '0);
    check("R1", "b2_out after reset", b2_out, '0);
    @(negedge clk);

    // R8: load both B-to-A latches, then toggle select and enables
    b1_drv = 1; b1_in = 12'h111; b2_drv = 1; b2_in = 12'h222; le_b1a = 1; le_b2a = 1;
    step();
    le_b1a = 0; le_b2a = 0; b1_in = 12'hEEE; b2_in = 12'hDDD;
    for (int i = 0; i < 6; i++) begin
      sel = i[0]; oe_a_n = i[1]; oe_b1_n = ~i[0]; oe_b2_n = i[2];
      #1;
      check("R8", "a_out stored bank", a_out, i[0] ? 12'h111 : 12'h222);
      #1;
      step();
    end
    quiet();

    // R9: keeper holds bank-1 level after release
    b1_drv = 1; b1_in = 12'hABC; step();
    b1_drv = 0; b1_in = 12'h000; sel = 1; le_b1a = 1;
    #1;
    check("R9", "a_out from bank1 keeper", a_out, 12'hABC);
    #1;
    step();
    quiet();

    // random traffic
    for (int n = 0; n < 1500; n++) begin
      logic [31:0] r;
      r = $urandom;
      sel = r[0]; le_b1a = r[1]; le_b2a = r[2]; le_ab1 = r[3]; le_ab2 = r[4];
      oe_a_n = r[5]; oe_b1_n = r[6]; oe_b2_n = r[7];
      a_drv = r[8] | r[9]; b1_drv = r[10] | r[11]; b2_drv = r[12] | r[13];
      a_in = W'($urandom); b1_in = W'($urandom); b2_in = W'($urandom);
      if (r[20:16] == 5'd0) rst_n = 1'b0; else rst_n = 1'b1;
      step();
    end
    rst_n = 1'b1;

    done = 1'b1;
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule